// File: doc/BRIEF.md
# Configurable LFSR Pattern Generator

This block produces a stream of pseudo-random test patterns from an n-bit linear feedback shift register. One parameter picks how the feedback is wired. In the external-XOR form, all tapped stages are summed into the top stage. In the internal-XOR form, the top stage is fed back into an XOR placed between stages. A second parameter holds the tap coefficients h1..hn-1 of the characteristic polynomial 1 + h1·x + … + x^n. Bit i of the state output is stage Xi.

The state steps once per clock while the enable is high. A seed load writes a new starting state, and a load takes priority over stepping. A zero seed would lock the register at zero, so it is replaced by state 1. The block remembers the last seed it loaded. It raises a one-cycle wrap pulse when stepping brings the state back to that seed, which marks the end of one full period.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: After reset the state is 1 (X0 = 1, all other stages 0), the remembered seed is 1, and wrap is 0.
- R2: When load is high at a clock edge, the state becomes the seed value at that edge, whatever en is.
- R3: A load whose seed is all zeros sets the state to 1.
- R4: When both load and en are low, the state does not change.
- R5: In the external-XOR form, each step moves stage X(i+1) into stage Xi. The new X(n-1) is X0 XORed with every stage Xi (1 ≤ i ≤ n-1) whose tap bit TAPS[i] is 1.
- R6: In the internal-XOR form, each step moves X(n-1) into X0. Each other stage Xi gets X(i-1) XORed with X(n-1) when TAPS[i] is 1, and plain X(i-1) otherwise.
- R7: With n = 3, the external-XOR form and TAPS = 3'b010 (1 + x + x^3), the states after loading state value 1 are 4, 2, 5, 6, 7, 3, 1, written as state[2:0].
- R8: With a primitive polynomial, the state never becomes zero and comes back to the seed after exactly 2^n − 1 steps.
- R9: wrap is high for one cycle after a step whose new state equals the remembered seed. A step that coincides with a load never raises it.
- R10: Over one full period of a primitive polynomial, taken circularly, the X0 stream has exactly one run of n ones and exactly one run of n−1 zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the register one step |
| load | input | 1 | Load the seed (takes priority over en) |
| seed | input | WIDTH | Seed value; bit i goes to stage Xi |
| state | output | WIDTH | Current register state; bit i is stage Xi |
| wrap | output | 1 | One-cycle pulse when stepping returns the state to the seed |

## Verification
Two functions can meet in one cycle: a seed load and the step that would close the period and raise wrap. The bench steps the register to one step short of the period. It then asserts load and en together, and expects the new seed in the state and wrap to stay low. Random stimulus also places loads (some with zero seeds) next to enabled steps and gaps in enable. Every cycle is compared with reference step functions for four configurations, which include the 8-bit internal-XOR polynomial 1 + x^2 + x^7 + x^8.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
   // Feedback arrangement of the shift register
   typedef enum logic {
      LFSR_STANDARD = 1'b0,  // external XOR: tapped stages summed into the top stage
      LFSR_MODULAR  = 1'b1   // internal XOR: top stage fed into XORs between stages
   } lfsr_form_e;
endpackage

// File: rtl/lfsr_step.sv
module lfsr_step
   import lfsr_pkg::*;
#(
   parameter int                WIDTH = 8,
   parameter lfsr_form_e        FORM  = LFSR_MODULAR,
   parameter logic [WIDTH-1:0]  TAPS  = 'h70
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   localparam int TOP = WIDTH - 1;

   generate
      if (FORM == LFSR_STANDARD) begin : g_external
         logic fb;
         always_comb begin
            fb = cur[0];
            for (int i = 1; i <= TOP; i++) begin
               fb = fb ^ (TAPS[i] & cur[i]);
            end
            nxt = {fb, cur[TOP:1]};
         end
      end else begin : g_internal
         always_comb begin
            nxt[0] = cur[TOP];
            for (int i = 1; i <= TOP; i++) begin
               nxt[i] = cur[i-1] ^ (TAPS[i] & cur[TOP]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] safe
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      safe = (raw == '0) ? ONE : raw;
   end
endmodule

// File: rtl/lfsr_wrap_detect.sv
module lfsr_wrap_detect #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   input  logic [WIDTH-1:0] seed_safe,
   input  logic [WIDTH-1:0] nxt,
   output logic             wrap
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] origin_q;
   logic             wrap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         origin_q <= ONE;
         wrap_q   <= 1'b0;
      end else begin
         if (load) begin
            origin_q <= seed_safe;
         end
         wrap_q <= advance && !load && (nxt == origin_q);
      end
   end

   assign wrap = wrap_q;
endmodule

// File: rtl/lfsr_pattern_gen.sv
module lfsr_pattern_gen
   import lfsr_pkg::*;
#(
   parameter int                WIDTH = 8,
   parameter lfsr_form_e        FORM  = LFSR_MODULAR,
   parameter logic [WIDTH-1:0]  TAPS  = 'h70
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] seed,
   output logic [WIDTH-1:0] state,
   output logic             wrap
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lfsr_pattern_gen: WIDTH must be at least 2");
      end
      if (TAPS[0] !== 1'b0) begin : g_bad_taps
         $error("lfsr_pattern_gen: TAPS bit 0 is unused and must be 0");
      end
   endgenerate

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] seed_safe;

   lfsr_step #(.WIDTH(WIDTH), .FORM(FORM), .TAPS(TAPS)) u_step (
      .cur (state_q),
      .nxt (nxt)
   );

   lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
      .raw  (seed),
      .safe (seed_safe)
   );

   lfsr_wrap_detect #(.WIDTH(WIDTH)) u_wrap (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .advance   (en),
      .seed_safe (seed_safe),
      .nxt       (nxt),
      .wrap      (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ONE;
      end else if (load) begin
         state_q <= seed_safe;
      end else if (en) begin
         state_q <= nxt;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/lfsr_pattern_gen_chk.sv
module lfsr_pattern_gen_chk
   import lfsr_pkg::*;
#(
   parameter int         WIDTH = 8,
   parameter lfsr_form_e FORM  = LFSR_MODULAR
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             load,
   input logic [WIDTH-1:0] seed,
   input logic [WIDTH-1:0] state,
   input logic             wrap
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   // R2: a nonzero seed lands in the state on the next cycle
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && seed != '0) |=> state == $past(seed));

   // R3: a zero seed becomes state 1
   p_zero_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && seed == '0) |=> state == ONE);

   // R4: idle cycles leave the state alone
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !en) |=> $stable(state));

   // R8: the register never reaches zero
   p_no_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

   // R9: wrap only follows an enabled step without a load
   p_wrap_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> ($past(en) && !$past(load)));

   // R9: a load suppresses wrap in the following cycle
   p_load_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !wrap);

   generate
      if (FORM == LFSR_STANDARD) begin : g_ext
         // R5: lower stages shift down by one
         p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !load) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));
      end else begin : g_int
         // R6: the top stage returns directly into X0
         p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !load) |=> state[0] == $past(state[WIDTH-1]));
      end
   endgenerate
endmodule

bind lfsr_pattern_gen lfsr_pattern_gen_chk #(.WIDTH(WIDTH), .FORM(FORM)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en),
   .load  (load),
   .seed  (seed),
   .state (state),
   .wrap  (wrap)
);

// File: tb/tb_lfsr_pattern_gen.sv
`timescale 1ns/1ps
module tb_lfsr_pattern_gen;
   import lfsr_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       load = 1'b0;
   logic [7:0] seed = '0;

   logic [7:0] st0, st1, st3;
   logic [2:0] st2;
   logic [3:0] wr;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   // 0: 8-bit internal XOR, primitive 1+x^4+x^5+x^6+x^8 (defaults)
   lfsr_pattern_gen dut (
      .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed),
      .state(st0), .wrap(wr[0]));
   // 1: 8-bit external XOR, same polynomial
   lfsr_pattern_gen #(.WIDTH(8), .FORM(LFSR_STANDARD), .TAPS(8'h70)) dut_ext8 (
      .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed),
      .state(st1), .wrap(wr[1]));
   // 2: 3-bit external XOR, 1+x+x^3
   lfsr_pattern_gen #(.WIDTH(3), .FORM(LFSR_STANDARD), .TAPS(3'b010)) dut_ext3 (
      .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed[2:0]),
      .state(st2), .wrap(wr[2]));
   // 3: 8-bit internal XOR, 1+x^2+x^7+x^8
   lfsr_pattern_gen #(.WIDTH(8), .FORM(LFSR_MODULAR), .TAPS(8'h84)) dut_m84 (
      .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed),
      .state(st3), .wrap(wr[3]));

   int         m_w   [4] = '{8, 8, 3, 8};
   bit         m_mod [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
   logic [7:0] m_taps[4] = '{8'h70, 8'h70, 8'h02, 8'h84};
   logic [7:0] m_st  [4];
   logic [7:0] m_sd  [4];
   bit         m_wr  [4];

   function automatic logic [7:0] mask_of(input int w);
      return 8'((9'd1 << w) - 9'd1);
   endfunction

   function automatic logic [7:0] ref_next(input logic [7:0] s, input int w,
                                           input bit modular, input logic [7:0] h);
      logic [7:0] r;
      logic fb;
      r = '0;
      if (!modular) begin
         fb = s[0];
         for (int i = 1; i < w; i++) fb = fb ^ (h[i] & s[i]);
         for (int i = 0; i < w - 1; i++) r[i] = s[i+1];
         r[w-1] = fb;
      end else begin
         r[0] = s[w-1];
         for (int i = 1; i < w; i++) r[i] = s[i-1] ^ (h[i] & s[w-1]);
      end
      return r;
   endfunction

   function automatic logic [7:0] ref_load(input logic [7:0] sd, input int w);
      logic [7:0] v;
      v = sd & mask_of(w);
      return (v == '0) ? 8'd1 : v;
   endfunction

   function automatic logic [7:0] act_state(input int k);
      case (k)
         0: return st0;
         1: return st1;
         2: return {5'b0, st2};
         default: return st3;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 4; k++) begin
         m_st[k] = 8'd1; m_sd[k] = 8'd1; m_wr[k] = 1'b0;
      end
   endtask

   task automatic model_update();
      for (int k = 0; k < 4; k++) begin
         logic [7:0] nx;
         nx = ref_next(m_st[k], m_w[k], m_mod[k], m_taps[k]);
         m_wr[k] = en && !load && (nx == m_sd[k]);
         if (load) begin
            m_st[k] = ref_load(seed, m_w[k]);
            m_sd[k] = m_st[k];
         end else if (en) begin
            m_st[k] = nx;
         end
      end
   endtask

   task automatic compare_all();
      for (int k = 0; k < 4; k++) begin
         string rq;
         rq = m_mod[k] ? "R6" : "R5";
         check(act_state(k) == m_st[k], rq, $sformatf("state inst%0d", k),
               act_state(k), m_st[k]);
         check(wr[k] == m_wr[k], "R9", $sformatf("wrap inst%0d", k),
               8'(wr[k]), 8'(m_wr[k]));
      end
   endtask

   // Starts and ends at a falling edge
   task automatic cycle(input bit l, input bit e, input logic [7:0] sd);
      load = l; en = e; seed = sd;
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      logic [7:0] hold_val;
      bit x0_bits[255];
      int wraps0, wraps1, wrap_at0, wrap_at1;
      logic [2:0] seq3[7] = '{3'd4, 3'd2, 3'd5, 3'd6, 3'd7, 3'd3, 3'd1};

      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset values
      check(st0 == 8'd1, "R1", "reset state inst0", st0, 8'd1);
      check(st1 == 8'd1, "R1", "reset state inst1", st1, 8'd1);
      check(st2 == 3'd1, "R1", "reset state inst2", {5'b0, st2}, 8'd1);
      check(st3 == 8'd1, "R1", "reset state inst3", st3, 8'd1);
      check(wr == 4'b0, "R1", "reset wrap", {4'b0, wr}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: three-stage sequence from state 1
      cycle(1'b1, 1'b0, 8'h01);
      for (int i = 0; i < 7; i++) begin
         cycle(1'b0, 1'b1, 8'h00);
         check(st2 == seq3[i], "R7", $sformatf("3-bit step %0d", i + 1),
               {5'b0, st2}, {5'b0, seq3[i]});
         check(wr[2] == (i == 6), "R7", $sformatf("3-bit wrap step %0d", i + 1),
               8'(wr[2]), 8'(i == 6));
      end

      // R3: zero seed becomes 1
      cycle(1'b1, 1'b0, 8'h00);
      check(st0 == 8'd1 && st1 == 8'd1 && st2 == 3'd1 && st3 == 8'd1, "R3",
            "zero seed load", st0, 8'd1);

      // R2: load wins over en
      cycle(1'b1, 1'b1, 8'h5A);
      check(st0 == 8'h5A, "R2", "load with en inst0", st0, 8'h5A);
      check(st2 == 3'd2, "R2", "load with en inst2", {5'b0, st2}, 8'd2);

      // R4: idle cycles hold
      cycle(1'b0, 1'b1, 8'h00);
      hold_val = st0;
      for (int i = 0; i < 4; i++) begin
         cycle(1'b0, 1'b0, 8'hFF);
         check(st0 == hold_val, "R4", "hold while idle", st0, hold_val);
      end

      // R8 / R10: full period of the primitive 8-bit polynomials
      cycle(1'b1, 1'b0, 8'h01);
      wraps0 = 0; wraps1 = 0; wrap_at0 = -1; wrap_at1 = -1;
      for (int i = 0; i < 255; i++) begin
         x0_bits[i] = st0[0];
         cycle(1'b0, 1'b1, 8'h00);
         if (st0 == 8'd0 || st1 == 8'd0)
            check(1'b0, "R8", "state reached zero", st0, 8'd1);
         if (wr[0]) begin wraps0++; wrap_at0 = i + 1; end
         if (wr[1]) begin wraps1++; wrap_at1 = i + 1; end
      end
      check(wraps0 == 1 && wrap_at0 == 255, "R8", "internal period",
            8'(wrap_at0), 8'd255);
      check(wraps1 == 1 && wrap_at1 == 255, "R8", "external period",
            8'(wrap_at1), 8'd255);
      begin
         int start, len, ones8, zeros7;
         start = 0;
         for (int i = 0; i < 255; i++)
            if (x0_bits[i] != x0_bits[(i + 254) % 255]) begin start = i; break; end
         ones8 = 0; zeros7 = 0; len = 0;
         for (int j = 0; j < 255; j++) begin
            int p;
            p = (start + j) % 255;
            len++;
            if (x0_bits[(p + 1) % 255] != x0_bits[p] || j == 254) begin
               if (x0_bits[p] && len == 8) ones8++;
               if (!x0_bits[p] && len == 7) zeros7++;
               len = 0;
            end
         end
         check(ones8 == 1, "R10", "runs of n ones", 8'(ones8), 8'd1);
         check(zeros7 == 1, "R10", "runs of n-1 zeros", 8'(zeros7), 8'd1);
      end

      // R9: load meets the period-closing step
      cycle(1'b1, 1'b0, 8'h01);
      for (int i = 0; i < 254; i++) cycle(1'b0, 1'b1, 8'h00);
      cycle(1'b1, 1'b1, 8'hC3);
      check(wr[0] == 1'b0 && wr[1] == 1'b0, "R9", "wrap on load collision",
            {6'b0, wr[1:0]}, 8'd0);
      check(st0 == 8'hC3, "R2", "state on load collision", st0, 8'hC3);

      // Random mix: R5, R6 and R9 against the reference model
      for (int i = 0; i < 3000; i++) begin
         bit l, e;
         logic [7:0] sd;
         l  = ($urandom % 16) == 0;
         e  = ($urandom % 4) != 0;
         sd = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
         cycle(l, e, sd);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule